// File: doc/BRIEF.md
# Pseudo-Associative Cache Controller

This block controls a direct-mapped cache whose array is treated as two halves. A CPU lookup first reads the line at the normal direct-mapped index. If that line does not match, the controller reads the partner line in the other half on the following cycle. The partner line sits at the same index with the top index bit inverted. A match there is a slow "pseudo-hit". When neither line matches, the controller fetches the word from the next memory level. This gives part of the conflict-miss benefit of a two-way cache while a primary hit still costs only a single cycle.

Each tag stores every address bit above the index, plus the top index bit. This lets a line that was moved into the partner slot be told apart from a line that naturally lives there. After a pseudo-hit, the two lines exchange slots, so the line just used sits in its primary slot. On a refill, the new line takes the primary slot and the line it displaces moves to the partner slot. Writes are sent straight through to memory, update any cached copy in place and never allocate a line. Every access returns a two-bit outcome code with its response.

Top module: `pac_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1 and `rsp_valid`, `rsp_kind` and `mem_req` are 0, and every line is invalid, so the first read of any address is a miss.
- R2: A read that matches at its primary index responds with `rsp_valid` in the cycle after acceptance. It returns kind 01 and the stored data, and issues no memory request.
- R3: A read that misses its primary slot but matches the partner slot (index with the top bit inverted) responds two cycles after acceptance. It returns kind 10 and the stored data, and issues no memory request.
- R4: After a pseudo-hit, the two lines have exchanged slots. The same address then hits in one cycle, and the line that was previously primary becomes a pseudo-hit.
- R5: A read that matches neither slot raises `mem_req` with `mem_we`=0 and the requested address. It holds the request until `mem_ack`, then responds in the next cycle with kind 11 and `mem_rdata`. Total latency is 2 + the memory wait.
- R6: On a refill, the new line is written to the primary slot. The old primary line moves to the partner slot only if it was valid. The old partner line is dropped only in that case.
- R7: `cpu_ready` is low while an access is in progress. A request raised during that time is ignored: it produces no response, no memory request and no cache fill.
- R8: A write raises `mem_req` with `mem_we`=1, its address and data, and responds one cycle after `mem_ack`. It updates the data of a matching cached line in place and does not allocate a line on a miss.
- R9: `rsp_kind` encodes 01 for a primary hit, 10 for a pseudo-hit and 11 for a miss. For a write, the code reports where the line was found. The code is 00 whenever `rsp_valid` is 0.
- R10: A line held in the partner slot does not satisfy an address whose primary slot is that partner slot. Such an address differs only in the top index bit and is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 for a write-through store, 0 for a read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_kind | output | 2 | Outcome code: 01 hit, 10 pseudo-hit, 11 miss, 00 none |
| rsp_data | output | DATA_W | Read data for the response |
| mem_req | output | 1 | Request to the next level, held until acknowledged |
| mem_we | output | 1 | 1 when the memory request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completion strobe |

## Verification
The hardest states to reach are a line sitting in its partner slot and an occupied partner slot holding a line of a different alias. From the ports, these arise only through particular sequences of misses. The bench builds them on purpose. It reads two or three addresses that share a primary index in a chosen order, so that later reads land exactly on a pseudo-hit, on a swap, or on an eviction. To cover the alias case, it reads an address whose index differs only in the top bit from a line already cached.

// File: rtl/pac_pkg.sv
package pac_pkg;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_HIT    = 2'b01,
        KIND_PSEUDO = 2'b10,
        KIND_MISS   = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE2 = 2'd1,
        ST_FETCH  = 2'd2,
        ST_WRITE  = 2'd3
    } state_e;

    function automatic kind_e kind_of(input logic at_primary, input logic at_partner);
        if (at_primary)      return KIND_HIT;
        else if (at_partner) return KIND_PSEUDO;
        else                 return KIND_MISS;
    endfunction

endpackage

// File: rtl/pac_line_store.sv
module pac_line_store #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic              ra_valid,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic              rb_valid,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic              wa_valid,
    input  logic [TAG_W-1:0]  wa_tag,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data
);
    localparam int LINES = 1 << IDX_W;

    logic              vld_w  [LINES];
    logic [TAG_W-1:0]  tag_w  [LINES];
    logic [DATA_W-1:0] data_w [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [DATA_W-1:0] d_q;
        logic              hit_wa, hit_wb;

        assign hit_wa = wa_en && (wa_idx == IDX_W'(i));
        assign hit_wb = wb_en && (wb_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                t_q <= '0;
                d_q <= '0;
            end else if (hit_wa) begin
                v_q <= wa_valid;
                t_q <= wa_tag;
                d_q <= wa_data;
            end else if (hit_wb) begin
                v_q <= wb_valid;
                t_q <= wb_tag;
                d_q <= wb_data;
            end
        end

        assign vld_w[i]  = v_q;
        assign tag_w[i]  = t_q;
        assign data_w[i] = d_q;
    end

    assign ra_valid = vld_w[ra_idx];
    assign ra_tag   = tag_w[ra_idx];
    assign ra_data  = data_w[ra_idx];
    assign rb_valid = vld_w[rb_idx];
    assign rb_tag   = tag_w[rb_idx];
    assign rb_data  = data_w[rb_idx];

    // Both write ports fire together only for a swap or a refill, always on partner slots
    AST_SWAP_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (wa_en && wb_en) |-> (wa_idx != wb_idx)); // R4

endmodule

// File: rtl/pac_probe_fsm.sv
module pac_probe_fsm
    import pac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       we,
    input  logic       hit_a,
    input  logic       hit_b,
    input  logic       mem_ack,
    output state_e     state,
    output logic       ev_hit,
    output logic       ev_pseudo,
    output logic       ev_fill,
    output logic       ev_wr,
    output logic       rsp_valid,
    output logic [1:0] rsp_kind
);
    state_e state_q, state_d;
    kind_e  kind_q, kind_d, wkind_q;
    logic   valid_q, valid_d, op_we_q, wdone;

    always_comb begin
        ev_hit    = (state_q == ST_IDLE)   && go && !we && hit_a;
        ev_wr     = (state_q == ST_IDLE)   && go && we;
        ev_pseudo = (state_q == ST_PROBE2) && hit_b;
        ev_fill   = (state_q == ST_FETCH)  && mem_ack;
        wdone     = (state_q == ST_WRITE)  && mem_ack;

        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    if (we)          state_d = ST_WRITE;
                    else if (!hit_a) state_d = ST_PROBE2;
                end
            end
            ST_PROBE2: state_d = hit_b ? ST_IDLE : ST_FETCH;
            ST_FETCH:  if (mem_ack) state_d = ST_IDLE;
            ST_WRITE:  if (mem_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase

        valid_d = ev_hit || ev_pseudo || ev_fill || wdone;
        kind_d  = KIND_NONE;
        if (ev_hit)         kind_d = KIND_HIT;
        else if (ev_pseudo) kind_d = KIND_PSEUDO;
        else if (ev_fill)   kind_d = KIND_MISS;
        else if (wdone)     kind_d = wkind_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_NONE;
            wkind_q <= KIND_NONE;
            valid_q <= 1'b0;
            op_we_q <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            valid_q <= valid_d;
            if (ev_wr) wkind_q <= kind_of(hit_a, hit_b);
            if (go && state_q == ST_IDLE) op_we_q <= we;
        end
    end

    assign state     = state_q;
    assign rsp_valid = valid_q;
    assign rsp_kind  = kind_q;

    AST_KIND_CODED: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_kind != KIND_NONE)); // R9
    AST_KIND_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_kind == KIND_NONE)); // R9
    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == KIND_HIT && !op_we_q) |-> $past(go && state_q == ST_IDLE)); // R2
    AST_PSEUDO_SECOND: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == KIND_PSEUDO && !op_we_q) |-> $past(state_q == ST_PROBE2)); // R3
    AST_FETCH_AFTER_PROBE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH && $past(state_q) != ST_FETCH) |-> $past(state_q == ST_PROBE2 && !hit_b)); // R5

endmodule

// File: rtl/pac_cache.sv
module pac_cache
    import pac_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    // tag keeps the top index bit so a relocated line stays distinguishable
    localparam int TAG_W = ADDR_W - IDX_W + 1;

    state_e            state;
    logic              go, ev_hit, ev_pseudo, ev_fill, ev_wr;
    logic [ADDR_W-1:0] addr_q, look_addr;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [IDX_W-1:0]  idx_p, idx_alt;
    logic [TAG_W-1:0]  tag_lk;
    logic              ra_valid, rb_valid, hit_a, hit_b;
    logic [TAG_W-1:0]  ra_tag, rb_tag;
    logic [DATA_W-1:0] ra_data, rb_data;
    logic              wa_en, wa_valid, wb_en, wb_valid;
    logic [TAG_W-1:0]  wa_tag, wb_tag;
    logic [DATA_W-1:0] wa_data, wb_data;

    assign cpu_ready = (state == ST_IDLE);
    assign go        = cpu_req && cpu_ready;
    assign look_addr = (state == ST_IDLE) ? cpu_addr : addr_q;
    assign idx_p     = look_addr[IDX_W-1:0];
    assign idx_alt   = {~idx_p[IDX_W-1], idx_p[IDX_W-2:0]};
    assign tag_lk    = look_addr[ADDR_W-1:IDX_W-1];
    assign hit_a     = ra_valid && (ra_tag == tag_lk);
    assign hit_b     = rb_valid && (rb_tag == tag_lk);

    pac_line_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (idx_p),
        .ra_valid(ra_valid),
        .ra_tag  (ra_tag),
        .ra_data (ra_data),
        .rb_idx  (idx_alt),
        .rb_valid(rb_valid),
        .rb_tag  (rb_tag),
        .rb_data (rb_data),
        .wa_en   (wa_en),
        .wa_idx  (idx_p),
        .wa_valid(wa_valid),
        .wa_tag  (wa_tag),
        .wa_data (wa_data),
        .wb_en   (wb_en),
        .wb_idx  (idx_alt),
        .wb_valid(wb_valid),
        .wb_tag  (wb_tag),
        .wb_data (wb_data)
    );

    pac_probe_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .we       (cpu_we),
        .hit_a    (hit_a),
        .hit_b    (hit_b),
        .mem_ack  (mem_ack),
        .state    (state),
        .ev_hit   (ev_hit),
        .ev_pseudo(ev_pseudo),
        .ev_fill  (ev_fill),
        .ev_wr    (ev_wr),
        .rsp_valid(rsp_valid),
        .rsp_kind (rsp_kind)
    );

    // Slot update plan: swap on pseudo-hit, fill with demotion on miss, in-place on store
    always_comb begin
        wa_en = 1'b0; wa_valid = 1'b1; wa_tag = ra_tag; wa_data = ra_data;
        wb_en = 1'b0; wb_valid = 1'b1; wb_tag = rb_tag; wb_data = rb_data;
        if (ev_pseudo) begin
            wa_en = 1'b1; wa_valid = 1'b1;     wa_tag = rb_tag; wa_data = rb_data;
            wb_en = 1'b1; wb_valid = ra_valid; wb_tag = ra_tag; wb_data = ra_data;
        end else if (ev_fill) begin
            wa_en = 1'b1; wa_valid = 1'b1;     wa_tag = tag_lk; wa_data = mem_rdata;
            wb_en = ra_valid;                  wb_tag = ra_tag; wb_data = ra_data;
        end else if (ev_wr) begin
            wa_en = hit_a; wa_data = cpu_wdata;
            wb_en = hit_b; wb_data = cpu_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (go) begin
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
            end
            if (ev_hit)         rdata_q <= ra_data;
            else if (ev_pseudo) rdata_q <= rb_data;
            else if (ev_fill)   rdata_q <= mem_rdata;
        end
    end

    assign rsp_data  = rdata_q;
    assign mem_req   = (state == ST_FETCH) || (state == ST_WRITE);
    assign mem_we    = (state == ST_WRITE);
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R5
    AST_READY_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> cpu_ready); // R7
    AST_NO_FILL_ON_STORE: assert property (@(posedge clk) disable iff (rst)
        ev_wr |-> !(hit_a && hit_b)); // R8

endmodule

// File: tb/tb_pac_cache.sv
module tb_pac_cache;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 3;
    localparam int DATA_W = 32;
    localparam int MEM_LAT = 3;
    localparam logic [1:0] K_HIT = 2'b01, K_PSEUDO = 2'b10, K_MISS = 2'b11;

    logic clk = 1'b0, rst = 1'b1;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_ready, rsp_valid, mem_req, mem_we;
    logic [1:0] rsp_kind;
    logic [DATA_W-1:0] rsp_data, mem_wdata;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic mem_ack = 1'b0;

    int tests = 0, fails = 0;
    int n_rd = 0, n_wr = 0;
    logic [ADDR_W-1:0] last_maddr;
    logic [DATA_W-1:0] last_mwdata;
    logic [DATA_W-1:0] bmem [1 << ADDR_W];

    always #(CLK_PERIOD/2) clk = ~clk;

    pac_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // next-level memory model, acts on falling edges
    initial begin
        int wait_n;
        for (int i = 0; i < (1 << ADDR_W); i++)
            bmem[i] = 32'hC000_0000 | (i << 8) | (i ^ 8'h3C);
        wait_n = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst) wait_n = 0;
            else if (mem_req) begin
                wait_n++;
                if (wait_n == MEM_LAT) begin
                    wait_n = 0;
                    mem_ack = 1'b1;
                    last_maddr = mem_addr;
                    if (mem_we) begin
                        bmem[mem_addr] = mem_wdata;
                        last_mwdata = mem_wdata;
                        n_wr++;
                    end else begin
                        mem_rdata = bmem[mem_addr];
                        n_rd++;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input bit we, input logic [DATA_W-1:0] wd,
                          output logic [1:0] kind, output logic [DATA_W-1:0] data, output int lat);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a; cpu_we = we; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        lat = 1;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        kind = rsp_kind;
        data = rsp_data;
    endtask

    task automatic expect_read(input logic [ADDR_W-1:0] a, input logic [1:0] ek,
                               input string req);
        logic [1:0] k; logic [DATA_W-1:0] d; int lat; int rd0;
        int elat;
        rd0 = n_rd;
        access(a, 1'b0, '0, k, d, lat);
        elat = (ek == K_HIT) ? 1 : (ek == K_PSEUDO) ? 2 : 2 + MEM_LAT;
        check(k == ek, req, $sformatf("kind @%0h", a), 32'(k), 32'(ek));
        check(d == bmem[a], req, $sformatf("data @%0h", a), d, bmem[a]);
        check(lat == elat, req, $sformatf("latency @%0h", a), 32'(lat), 32'(elat));
        check((n_rd - rd0) == ((ek == K_MISS) ? 1 : 0), req, $sformatf("mem reads @%0h", a),
              32'(n_rd - rd0), (ek == K_MISS) ? 1 : 0);
        if (ek == K_MISS)
            check(last_maddr == a, req, "refill address", 32'(last_maddr), 32'(a));
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(cpu_ready == 1'b1, "R1", "ready after reset", 32'(cpu_ready), 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
        check(rsp_kind == 2'b00, "R1/R9", "kind after reset", 32'(rsp_kind), 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 0);
        expect_read(8'h10, K_MISS, "R1");
        expect_read(8'h04, K_MISS, "R1");
    endtask

    task automatic t_miss_hit();
        do_reset();
        expect_read(8'h13, K_MISS, "R5");
        expect_read(8'h13, K_HIT, "R2");
        @(negedge clk);
        check(rsp_kind == 2'b00 && !rsp_valid, "R9", "kind idle after rsp", 32'(rsp_kind), 0);
    endtask

    task automatic t_pseudo_swap();
        do_reset();
        expect_read(8'h10, K_MISS, "R5");
        expect_read(8'h20, K_MISS, "R6");   // 0x10 demoted to partner slot
        expect_read(8'h10, K_PSEUDO, "R3");
        expect_read(8'h10, K_HIT, "R4");    // swapped back to primary
        expect_read(8'h20, K_PSEUDO, "R4");
    endtask

    task automatic t_evict();
        do_reset();
        expect_read(8'h10, K_MISS, "R6");
        expect_read(8'h20, K_MISS, "R6");
        expect_read(8'h30, K_MISS, "R6");   // 0x10 dropped, 0x20 in partner
        expect_read(8'h30, K_HIT, "R6");
        expect_read(8'h20, K_PSEUDO, "R6");
        expect_read(8'h10, K_MISS, "R6");
    endtask

    task automatic t_alias();
        do_reset();
        expect_read(8'h10, K_MISS, "R10");
        expect_read(8'h14, K_MISS, "R10");  // partner slot holds 0x10, not 0x14
        expect_read(8'h10, K_HIT, "R6");    // invalid primary not demoted over it
        expect_read(8'h14, K_HIT, "R10");
    endtask

    task automatic t_busy();
        int rsps; int rd0;
        do_reset();
        rd0 = n_rd; rsps = 0;
        cpu_req = 1'b1; cpu_addr = 8'h11; cpu_we = 1'b0;
        @(negedge clk);
        cpu_req = 1'b0;
        check(cpu_ready == 1'b0, "R7", "ready low while busy", 32'(cpu_ready), 0);
        cpu_req = 1'b1; cpu_addr = 8'h21;
        @(negedge clk);
        cpu_req = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (rsp_valid) rsps++;
            @(negedge clk);
        end
        check(rsps == 1, "R7", "responses for one accepted read", 32'(rsps), 1);
        check(n_rd - rd0 == 1, "R7", "memory reads", 32'(n_rd - rd0), 1);
        expect_read(8'h11, K_HIT, "R7");
        expect_read(8'h21, K_MISS, "R7");   // ignored request left no line
    endtask

    task automatic t_write();
        logic [1:0] k; logic [DATA_W-1:0] d; int lat; int wr0;
        do_reset();
        expect_read(8'h10, K_MISS, "R8");
        wr0 = n_wr;
        access(8'h10, 1'b1, 32'hDEAD_0010, k, d, lat);
        check(k == K_HIT, "R8/R9", "write kind primary", 32'(k), 32'(K_HIT));
        check(n_wr - wr0 == 1 && last_maddr == 8'h10, "R8", "write-through addr",
              32'(last_maddr), 32'h10);
        check(last_mwdata == 32'hDEAD_0010, "R8", "write-through data", last_mwdata, 32'hDEAD_0010);
        check(lat == 1 + MEM_LAT, "R8", "write latency", 32'(lat), 1 + MEM_LAT);
        expect_read(8'h10, K_HIT, "R8");
        access(8'h50, 1'b1, 32'hBEEF_0050, k, d, lat);
        check(k == K_MISS, "R8/R9", "write kind miss", 32'(k), 32'(K_MISS));
        expect_read(8'h50, K_MISS, "R8");   // no allocate on write miss
        expect_read(8'h20, K_MISS, "R8");   // 0x50 demoted, 0x20 primary
        access(8'h50, 1'b1, 32'hCAFE_0050, k, d, lat);
        check(k == K_PSEUDO, "R8/R9", "write kind partner", 32'(k), 32'(K_PSEUDO));
        expect_read(8'h50, K_PSEUDO, "R8");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_miss_hit();
        t_pseudo_swap();
        t_evict();
        t_alias();
        t_busy();
        t_write();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule